// File: doc/BRIEF.md
# Threshold-Logic Block-Save Multiplier

This block multiplies two unsigned operands. Every partial-product bit is formed by an AND gate and placed in the column equal to the sum of its two bit positions. The resulting bit matrix is compressed without any carry chain. The matrix is cut into tiles that are at most four rows tall and two columns wide. Each tile is collapsed into a 4-bit count by a small counter. That counter is built as two layers of linear threshold gates instead of a tree of full adders.

The first layer compares the tile's weighted bit total against every integer bound. The second layer combines those comparisons with +1/-1 weights, which marks the intervals where each count bit is high. The counts are laid out in alternating lanes, so no two counts in one lane share a column. Each pass therefore halves the row count relative to the four-row tiles. With the default width, two passes leave exactly two rows, and a grouped carry-lookahead adder sums them. The product is captured in an output register behind a valid/ready handshake, one operation per cycle when the consumer keeps up.

Top module: `tl_bsr_multiplier`

## Requirements
- R1: For every pair of unsigned W-bit operands (W=8 by default), the registered product equals the full 2W-bit arithmetic product.
- R2: An operand pair is accepted on a rising clock edge where `in_valid_i` and `in_ready_o` are both high. Right after that edge, `out_valid_o` is high and `prod_o` holds that pair's product.
- R3: While `out_valid_o` is high and `out_ready_i` is low, the following hold. `prod_o` and `out_valid_o` stay unchanged. `in_ready_o` is low. Operands presented during the stall are not taken.
- R4: `in_ready_o` is high whenever `out_ready_i` is high or `out_valid_o` is low. This allows back-to-back accepts on consecutive edges. After a consumed result with no new input, `out_valid_o` falls on the next edge.
- R5: While `rst_ni` is low, `out_valid_o` is 0, `prod_o` is 0 and `in_ready_o` is 1. Asserting reset clears a pending result immediately.
- R6: A tile counter has a 4-bit lower-column input with weight 1 and a 4-bit upper-column input with weight 2. Its 4-bit output, with bit 0 as the least significant bit, equals the weighted total, which ranges from 0 to 12.
- R7: Partial product a[j]&b[i] sits in column i+j. Each reduction pass maps every tile of four rows by two columns to one 4-bit count at the tile's lower column, in lane (tile pair index mod 2). After the passes, the two remaining rows add up to the product. No count bit falls above column 2W-1, and the final adder produces no carry out.
- R8: The extreme operand values give exact results. These are zero with anything, one with anything, and both operands all ones, which gives 2^(2W) - 2^(W+1) + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair is present |
| in_ready_o | output | 1 | Block can take an operand pair this cycle |
| mcand_i | input | W | Multiplicand, unsigned |
| mplier_i | input | W | Multiplier, unsigned |
| out_valid_o | output | 1 | `prod_o` holds an unconsumed result |
| out_ready_i | input | 1 | Consumer takes the result this cycle |
| prod_o | output | 2W | Registered unsigned product |

## Verification
The tile counter is driven on its own through all 256 input combinations. This separates the lower-column weight from the upper-column weight, and it checks the wrap points of each interval. The full multiplier first sees walking-one and walking-zero operand pairs, which place a lone partial product, or a nearly full matrix, at every column position and expose misplaced tiles or lanes. It then sees the extreme values and finally every one of the 65,536 pairs back to back, which also proves the one-per-cycle handshake. Separate stall, drain and mid-operation reset sequences tell correct holding apart from dropped or overwritten results.

// File: rtl/tl_bsr_pkg.sv
package tl_bsr_pkg;

  // Tile geometry of one block counter
  localparam int BLK_ROWS  = 4;
  localparam int BLK_COLS  = 2;
  localparam int BLK_LANES = 2;
  localparam int BLK_MAX   = BLK_ROWS * 3;
  localparam int BLK_BITS  = $clog2(BLK_MAX + 1);

  // Rows left after one pass over r rows
  function automatic int rows_after(input int r);
    return BLK_LANES * ((r + BLK_ROWS - 1) / BLK_ROWS);
  endfunction

  // Rows present at the input of pass s (s = 0 is the partial-product matrix)
  function automatic int stage_rows(input int w, input int s);
    int r;
    r = w;
    for (int i = 0; i < s; i++) r = rows_after(r);
    return r;
  endfunction

  // Number of passes needed to reach two rows
  function automatic int num_passes(input int w);
    int r;
    int n;
    r = w;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (r > BLK_LANES) begin
        r = rows_after(r);
        n++;
      end
    end
    return n;
  endfunction

  // Second-layer +1 taps for count bit j: threshold k opens a high interval
  function automatic logic [BLK_MAX-1:0] open_taps(input int j);
    logic [BLK_MAX-1:0] m;
    m = '0;
    for (int k = 1; k <= BLK_MAX; k++)
      if ((k % (1 << (j + 1))) == (1 << j)) m = m | ({{(BLK_MAX-1){1'b0}}, 1'b1} << (k - 1));
    return m;
  endfunction

  // Second-layer -1 taps for count bit j: threshold k closes a high interval
  function automatic logic [BLK_MAX-1:0] close_taps(input int j);
    logic [BLK_MAX-1:0] m;
    m = '0;
    for (int k = 1; k <= BLK_MAX; k++)
      if ((k % (1 << (j + 1))) == 0) m = m | ({{(BLK_MAX-1){1'b0}}, 1'b1} << (k - 1));
    return m;
  endfunction

endpackage

// File: rtl/tl_block_counter.sv
module tl_block_counter
  import tl_bsr_pkg::*;
(
  input  logic [BLK_ROWS-1:0] lo_i,
  input  logic [BLK_ROWS-1:0] hi_i,
  output logic [BLK_BITS-1:0] cnt_o
);

  // Weighted input total: lower column counts 1, upper column counts 2
  int wsum;
  assign wsum = $countones(lo_i) + 2 * $countones(hi_i);

  // Layer 1: one threshold gate per integer bound 1..BLK_MAX
  logic [BLK_MAX-1:0] thr;
  for (genvar k = 0; k < BLK_MAX; k++) begin : g_thr
    assign thr[k] = (wsum >= k + 1);
  end

  // Layer 2: +1/-1 weighted sum of comparisons, fires when positive
  for (genvar j = 0; j < BLK_BITS; j++) begin : g_bit
    localparam logic [BLK_MAX-1:0] OPEN  = open_taps(j);
    localparam logic [BLK_MAX-1:0] CLOSE = close_taps(j);
    assign cnt_o[j] = ($countones(thr & OPEN) > $countones(thr & CLOSE));
  end

endmodule

// File: rtl/tl_reduce_pass.sv
module tl_reduce_pass
  import tl_bsr_pkg::*;
#(
  parameter  int COLS  = 16,
  parameter  int RIN   = 8,
  localparam int GRPS  = (RIN + BLK_ROWS - 1) / BLK_ROWS,
  localparam int PAIRS = COLS / BLK_COLS,
  localparam int ROUT  = BLK_LANES * GRPS
) (
  input  logic [RIN-1:0][COLS-1:0]  mat_i,
  output logic [ROUT-1:0][COLS-1:0] mat_o,
  output logic                      spill_o
);

  logic [BLK_BITS-1:0] cnt [GRPS][PAIRS];
  logic [GRPS-1:0]     spill_v;

  // One counter per tile of BLK_ROWS rows by BLK_COLS columns
  for (genvar g = 0; g < GRPS; g++) begin : g_grp
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      logic [BLK_ROWS-1:0] lo;
      logic [BLK_ROWS-1:0] hi;
      for (genvar r = 0; r < BLK_ROWS; r++) begin : g_row
        if (g * BLK_ROWS + r < RIN) begin : g_live
          assign lo[r] = mat_i[g*BLK_ROWS+r][p*BLK_COLS];
          assign hi[r] = mat_i[g*BLK_ROWS+r][p*BLK_COLS+1];
        end else begin : g_pad
          assign lo[r] = 1'b0;
          assign hi[r] = 1'b0;
        end
      end
      tl_block_counter u_cnt (
        .lo_i  (lo),
        .hi_i  (hi),
        .cnt_o (cnt[g][p])
      );
    end
    // Upper count bits of the last tile pair land beyond the matrix
    assign spill_v[g] = |cnt[g][PAIRS-1][BLK_BITS-1:BLK_COLS];
  end

  assign spill_o = |spill_v;

  // Placement: even tile pairs in lane 0, odd in lane 1, never overlapping
  for (genvar ro = 0; ro < ROUT; ro++) begin : g_orow
    for (genvar c = 0; c < COLS; c++) begin : g_ocol
      localparam int G    = ro / BLK_LANES;
      localparam int LANE = ro % BLK_LANES;
      localparam int PA   = c / BLK_COLS;
      localparam int PSEL = ((PA % BLK_LANES) == LANE) ? PA : PA - 1;
      localparam int J    = c - PSEL * BLK_COLS;
      if (PSEL >= 0) begin : g_src
        assign mat_o[ro][c] = cnt[G][PSEL][J];
      end else begin : g_zero
        assign mat_o[ro][c] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/tl_cla_adder.sv
module tl_cla_adder #(
  parameter  int N    = 16,
  parameter  int GRP  = 4,
  localparam int NGRP = (N + GRP - 1) / GRP,
  localparam int NPAD = NGRP * GRP
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);

  logic [NPAD-1:0] gen;
  logic [NPAD-1:0] prop;
  logic [NPAD-1:0] cry;
  logic [NGRP:0]   gcy;

  assign gen    = NPAD'(x_i & y_i);
  assign prop   = NPAD'(x_i ^ y_i);
  assign gcy[0] = 1'b0;

  // Each carry inside a group is a flat sum of products of g/p and group carry-in
  for (genvar q = 0; q < NGRP; q++) begin : g_grp
    localparam int B = q * GRP;
    assign cry[B] = gcy[q];
    for (genvar t = 1; t <= GRP; t++) begin : g_cy
      logic [t:0] trm;
      assign trm[0] = gcy[q] & (&prop[B+t-1:B]);
      for (genvar j = 0; j < t; j++) begin : g_term
        if (j == t - 1) begin : g_last
          assign trm[j+1] = gen[B+j];
        end else begin : g_mid
          assign trm[j+1] = gen[B+j] & (&prop[B+t-1:B+j+1]);
        end
      end
      if (t < GRP) begin : g_in
        assign cry[B+t] = |trm;
      end else begin : g_out
        assign gcy[q+1] = |trm;
      end
    end
  end

  assign sum_o = prop[N-1:0] ^ cry[N-1:0];

  if (NPAD > N) begin : g_cout_pad
    assign cout_o = cry[N];
  end else begin : g_cout_full
    assign cout_o = gcy[NGRP];
  end

endmodule

// File: rtl/tl_bsr_multiplier.sv
module tl_bsr_multiplier
  import tl_bsr_pkg::*;
#(
  parameter int W       = 8,
  parameter int CLA_GRP = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [2*W-1:0] prod_o
);

  localparam int COLS  = 2 * W;
  localparam int NPASS = num_passes(W);

  // Partial-product matrix: row i is the multiplicand gated by multiplier bit i
  logic [W-1:0][COLS-1:0] pp_mat;
  for (genvar i = 0; i < W; i++) begin : g_pp
    assign pp_mat[i] = COLS'(mcand_i & {W{mplier_i[i]}}) << i;
  end

  // Chain of block-save passes
  logic [NPASS-1:0] spill_vec;
  for (genvar s = 0; s < NPASS; s++) begin : gen_pass
    localparam int RIN  = stage_rows(W, s);
    localparam int ROUT = stage_rows(W, s + 1);
    logic [ROUT-1:0][COLS-1:0] mat;
    if (s == 0) begin : g_first
      tl_reduce_pass #(.COLS(COLS), .RIN(RIN)) u_pass (
        .mat_i   (pp_mat),
        .mat_o   (mat),
        .spill_o (spill_vec[s])
      );
    end else begin : g_next
      tl_reduce_pass #(.COLS(COLS), .RIN(RIN)) u_pass (
        .mat_i   (gen_pass[s-1].mat),
        .mat_o   (mat),
        .spill_o (spill_vec[s])
      );
    end
  end

  // Named internal events for the checker
  logic [COLS-1:0] sum_x;
  logic [COLS-1:0] sum_y;
  logic [COLS-1:0] prod_d;
  logic            spill_any;
  logic            add_cout;
  logic            accept;

  assign sum_x     = gen_pass[NPASS-1].mat[0];
  assign sum_y     = gen_pass[NPASS-1].mat[1];
  assign spill_any = |spill_vec;

  tl_cla_adder #(.N(COLS), .GRP(CLA_GRP)) u_cla (
    .x_i    (sum_x),
    .y_i    (sum_y),
    .sum_o  (prod_d),
    .cout_o (add_cout)
  );

  // Output register with valid/ready handshake
  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      prod_o      <= '0;
    end else if (accept) begin
      out_valid_o <= 1'b1;
      prod_o      <= prod_d;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/tl_bsr_multiplier_chk.sv
module tl_bsr_multiplier_chk #(
  parameter int W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           in_valid_i,
  input logic           in_ready_o,
  input logic [W-1:0]   mcand_i,
  input logic [W-1:0]   mplier_i,
  input logic           out_valid_o,
  input logic           out_ready_i,
  input logic [2*W-1:0] prod_o,
  input logic [2*W-1:0] sum_x,
  input logic [2*W-1:0] sum_y,
  input logic [2*W-1:0] prod_d,
  input logic           spill_any,
  input logic           add_cout
);

  localparam int COLS = 2 * W;

  logic [COLS-1:0] exp_prod;
  logic [COLS:0]   op_total;
  assign exp_prod = COLS'(mcand_i) * COLS'(mplier_i);
  assign op_total = (COLS+1)'(sum_x) + (COLS+1)'(sum_y);

  AST_OPERANDS_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_total == {1'b0, exp_prod}); // R7

  AST_ADDER_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_d == op_total[COLS-1:0]); // R7

  AST_NO_SPILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spill_any); // R7

  AST_NO_CARRY_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !add_cout); // R7

  AST_PRODUCT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o && (prod_o == $past(exp_prod))); // R2

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(prod_o)); // R3

  AST_NO_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_i |-> in_ready_o); // R4

  AST_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !in_valid_i |=> !out_valid_o); // R4

endmodule

bind tl_bsr_multiplier tl_bsr_multiplier_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .mcand_i     (mcand_i),
  .mplier_i    (mplier_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .prod_o      (prod_o),
  .sum_x       (sum_x),
  .sum_y       (sum_y),
  .prod_d      (prod_d),
  .spill_any   (spill_any),
  .add_cout    (add_cout)
);

// File: tb/tl_bsr_multiplier_tb.sv
`timescale 1ns/1ps
module tl_bsr_multiplier_tb;

  localparam int W    = 8;
  localparam int COLS = 2 * W;
  localparam int WD   = 150000;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic            in_ready_o;
  logic [W-1:0]    mcand_i = '0;
  logic [W-1:0]    mplier_i = '0;
  logic            out_valid_o;
  logic            out_ready_i = 1'b1;
  logic [COLS-1:0] prod_o;

  logic [3:0] blk_lo = '0;
  logic [3:0] blk_hi = '0;
  logic [3:0] blk_cnt;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk_i = ~clk_i;

  tl_bsr_multiplier #(.W(W)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .mcand_i     (mcand_i),
    .mplier_i    (mplier_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .prod_o      (prod_o)
  );

  tl_block_counter u_blk (
    .lo_i  (blk_lo),
    .hi_i  (blk_hi),
    .cnt_o (blk_cnt)
  );

  task automatic check_eq(input string req, input string what,
                          input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Presents one pair just after a falling edge, checks it one edge later
  task automatic apply(input int a, input int b, input string req);
    mcand_i    = W'(a);
    mplier_i   = W'(b);
    in_valid_i = 1'b1;
    #1;
    check_eq("R4", "in_ready before accept", longint'(in_ready_o), 1);
    @(negedge clk_i);
    check_eq("R2", "out_valid after accept", longint'(out_valid_o), 1);
    check_eq(req, $sformatf("product %0d*%0d", a, b), longint'(prod_o),
             longint'(a) * longint'(b));
  endtask

  task automatic t_reset();
    check_eq("R5", "out_valid in reset", longint'(out_valid_o), 0);
    check_eq("R5", "prod in reset", longint'(prod_o), 0);
    check_eq("R5", "in_ready in reset", longint'(in_ready_o), 1);
  endtask

  task automatic t_block_counter();
    for (int v = 0; v < 256; v++) begin
      int expv;
      blk_lo = v[3:0];
      blk_hi = v[7:4];
      expv = 0;
      for (int i = 0; i < 4; i++) begin
        if (blk_lo[i]) expv = expv + 1;
        if (blk_hi[i]) expv = expv + 2;
      end
      #1;
      check_eq("R6", $sformatf("tile count lo=%0h hi=%0h", blk_lo, blk_hi),
               longint'(blk_cnt), longint'(expv));
    end
  endtask

  task automatic t_corners();
    apply(0, 0, "R8");
    apply(0, 255, "R8");
    apply(255, 0, "R8");
    apply(1, 1, "R8");
    apply(1, 255, "R8");
    apply(255, 1, "R8");
    apply(128, 128, "R8");
    apply(255, 255, "R8");
    in_valid_i = 1'b0;
    @(negedge clk_i);
    check_eq("R4", "drain after last result", longint'(out_valid_o), 0);
  endtask

  task automatic t_walking();
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        apply(1 << i, 1 << j, "R7");
        apply(255 ^ (1 << i), 255 ^ (1 << j), "R7");
      end
    end
    in_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_exhaustive();
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        apply(a, b, "R1");
      end
    end
    in_valid_i = 1'b0;
    @(negedge clk_i);
    check_eq("R4", "idle after sweep", longint'(out_valid_o), 0);
  endtask

  task automatic t_backpressure();
    out_ready_i = 1'b0;
    apply(37, 201, "R3");
    mcand_i    = 8'd99;
    mplier_i   = 8'd3;
    in_valid_i = 1'b1;
    #1;
    check_eq("R3", "in_ready during stall", longint'(in_ready_o), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      check_eq("R3", "valid held in stall", longint'(out_valid_o), 1);
      check_eq("R3", "product held in stall", longint'(prod_o), 37 * 201);
      check_eq("R3", "in_ready low in stall", longint'(in_ready_o), 0);
    end
    out_ready_i = 1'b1;
    #1;
    check_eq("R4", "in_ready when consumer ready", longint'(in_ready_o), 1);
    @(negedge clk_i);
    check_eq("R2", "next pair after stall", longint'(prod_o), 297);
    check_eq("R2", "valid after stall", longint'(out_valid_o), 1);
    in_valid_i = 1'b0;
    @(negedge clk_i);
    check_eq("R4", "drain after stall", longint'(out_valid_o), 0);
  endtask

  task automatic t_reset_midway();
    out_ready_i = 1'b0;
    apply(200, 150, "R1");
    in_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check_eq("R5", "valid cleared by reset", longint'(out_valid_o), 0);
    check_eq("R5", "prod cleared by reset", longint'(prod_o), 0);
    check_eq("R5", "in_ready in reset", longint'(in_ready_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    out_ready_i = 1'b1;
    @(negedge clk_i);
    apply(17, 19, "R1");
    in_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_block_counter();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_corners();
    t_walking();
    t_backpressure();
    t_reset_midway();
    t_exhaustive();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk_i);
    n_checks++;
    n_errors++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule